// File: doc/BRIEF.md
# Host memory-window bus slave

This block lets a host on a 16-bit ISA-style expansion bus see an on-chip word buffer as a slice of its memory map. The host starts each cycle by presenting a 20-bit address and pulsing the address latch enable. The slave brings the bus strobes into its own clock domain with two-flop synchronizers and latches the address when the latch enable falls. It responds only if the latched address lies in the fixed window 0xD0000 to 0xDFFFF and the DMA qualifier (AEN) is low. A write strobe stores the bus data word into the buffer. A read strobe drives data back after a short wait. During that wait the channel-ready line is held low so that the host stretches its cycle.

The buffer is a true dual-port RAM written so that block RAM can be inferred. Its second port belongs to the rest of the chip, which can fill data for the host and collect what the host wrote. The low address bits form the word index. With the default depth of 1024 words the window aliases every 1024 words. Setting `BUF_AW` to 16 gives the full 64K-word buffer.

Top module: `isa_win_slave`

## Requirements
- R1: After reset, `bus_rdy` is 1 and `bus_d_oe` is 0.
- R2: A host write strobe to an address in 0xD0000..0xDFFFF, with AEN low, stores `bus_d_i` at buffer word index `addr[BUF_AW-1:0]`. The stored word can be read back on the local port.
- R3: A cycle whose latched address is outside 0xD0000..0xDFFFF is ignored. A write changes no buffer word. A read leaves `bus_rdy` at 1 and `bus_d_oe` at 0.
- R4: A cycle with AEN high is ignored in the same way as R3, even when its address is inside the window.
- R5: On a decoded read, `bus_rdy` goes low for exactly `WAIT_CLKS` (default 2) clocks and then returns to 1. From then on, `bus_d_o` carries the buffer word at the latched index.
- R6: `bus_d_oe` is 1 only during a decoded read. It returns to 0 within four clocks after the read strobe is released.
- R7: A word written through the local port (`ub_en`=1, `ub_we`=1) is returned by a later host read of the matching window address.
- R8: The address is taken when the latch enable falls. A change on `bus_addr` after that edge does not change the word that the cycle accesses.
- R9: Each assertion of the write strobe performs exactly one write, using the data present when the strobe is first seen. A later change on `bus_d_i` while the strobe is held does not alter the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ale | input | 1 | Address latch enable, address taken on falling edge |
| bus_aen | input | 1 | DMA qualifier, high means ignore the cycle |
| bus_memr_n | input | 1 | Memory read strobe, active low |
| bus_memw_n | input | 1 | Memory write strobe, active low |
| bus_addr | input | BUS_AW | Host address |
| bus_d_i | input | BUS_DW | Data from host |
| bus_d_o | output | BUS_DW | Data to host |
| bus_d_oe | output | 1 | Output enable for the data pads |
| bus_rdy | output | 1 | Channel ready, low stretches the cycle |
| ub_en | input | 1 | Local port enable |
| ub_we | input | 1 | Local port write enable |
| ub_addr | input | BUF_AW | Local port word index |
| ub_wdata | input | BUS_DW | Local port write data |
| ub_rdata | output | BUS_DW | Local port read data, one clock after enable |

## Verification
The bench drives the two addresses just inside the window edges and the two just outside. A decoder with a wrong compare width or base would either store a word that should be ignored or miss 0xDFFFF. It repeats an in-window cycle with AEN high, so a slave that ignored the qualifier would be caught overwriting a prefilled word or asserting ready low. It counts the ready-low clocks of each read, which exposes a wait counter that is off by one. It also moves the address after the latch enable falls and changes the data while the write strobe is held. A slave that tracks the live bus, or that writes on every clock of the strobe, would store the wrong word.

// File: rtl/isa_win_pkg.sv
package isa_win_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RWAIT = 2'd1,
    ST_RDRV  = 2'd2,
    ST_WHOLD = 2'd3
  } win_state_t;

  localparam int SYNC_STAGES = 2;
  localparam int STROBE_CNT  = 4;
endpackage

// File: rtl/isa_win_sync.sv
module isa_win_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_i[g]};
      end
      assign sync_o[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/isa_win_decode.sv
module isa_win_decode #(
  parameter int              BUS_AW   = 20,
  parameter int              BUF_AW   = 10,
  parameter int              WIN_BITS = 16,
  parameter logic [BUS_AW-1:0] WIN_BASE = 20'hD0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_s,
  input  logic              aen_s,
  input  logic [BUS_AW-1:0] bus_addr,
  output logic              hit_q,
  output logic [BUF_AW-1:0] idx_q
);
  localparam int TAG_W = BUS_AW - WIN_BITS;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[BUS_AW-1:WIN_BITS];

  logic ale_d;
  logic ale_fall;
  logic tag_match;

  assign ale_fall  = ale_d & ~ale_s;
  assign tag_match = (bus_addr[BUS_AW-1:WIN_BITS] == WIN_TAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_d <= 1'b0;
      hit_q <= 1'b0;
      idx_q <= '0;
    end else begin
      ale_d <= ale_s;
      if (ale_fall) begin
        hit_q <= tag_match & ~aen_s;
        idx_q <= bus_addr[BUF_AW-1:0];
      end
    end
  end
endmodule

// File: rtl/isa_win_ctrl.sv
module isa_win_ctrl
  import isa_win_pkg::*;
#(
  parameter int BUS_DW    = 16,
  parameter int BUF_AW    = 10,
  parameter int WAIT_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              memr_s,
  input  logic              memw_s,
  input  logic              aen_s,
  input  logic              hit_q,
  input  logic [BUF_AW-1:0] idx_q,
  input  logic [BUS_DW-1:0] bus_d_i,
  output logic [BUS_DW-1:0] bus_d_o,
  output logic              bus_d_oe,
  output logic              bus_rdy,
  output logic              a_en,
  output logic              a_we,
  output logic [BUF_AW-1:0] a_addr,
  output logic [BUS_DW-1:0] a_wdata,
  input  logic [BUS_DW-1:0] a_rdata
);
  localparam int CW = (WAIT_CLKS > 1) ? $clog2(WAIT_CLKS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(WAIT_CLKS - 1);

  win_state_t        state;
  logic [CW-1:0]     wcnt;
  logic              memr_d, memw_d;
  logic              rd_rise, wr_rise, sel;
  logic              rd_req;
  logic [BUF_AW-1:0] wr_idx;

  assign sel     = hit_q & ~aen_s;
  assign rd_rise = memr_s & ~memr_d;
  assign wr_rise = memw_s & ~memw_d;
  assign rd_req  = (state == ST_IDLE) & rd_rise & ~memw_s & sel;

  assign a_en   = rd_req | a_we;
  assign a_addr = a_we ? wr_idx : idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wcnt     <= '0;
      memr_d   <= 1'b0;
      memw_d   <= 1'b0;
      bus_rdy  <= 1'b1;
      bus_d_oe <= 1'b0;
      bus_d_o  <= '0;
      a_we     <= 1'b0;
      wr_idx   <= '0;
      a_wdata  <= '0;
    end else begin
      memr_d <= memr_s;
      memw_d <= memw_s;
      a_we   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (rd_req) begin
            state    <= ST_RWAIT;
            wcnt     <= '0;
            bus_rdy  <= 1'b0;
            bus_d_oe <= 1'b1;
          end else if (wr_rise & ~memr_s & sel) begin
            state   <= ST_WHOLD;
            a_we    <= 1'b1;
            wr_idx  <= idx_q;
            a_wdata <= bus_d_i;
          end
        end
        ST_RWAIT: begin
          if (!memr_s) begin
            state    <= ST_IDLE;
            bus_rdy  <= 1'b1;
            bus_d_oe <= 1'b0;
          end else if (wcnt == CNT_LAST) begin
            state   <= ST_RDRV;
            bus_rdy <= 1'b1;
            bus_d_o <= a_rdata;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_RDRV: begin
          if (!memr_s) begin
            state    <= ST_IDLE;
            bus_d_oe <= 1'b0;
          end
        end
        ST_WHOLD: begin
          if (!memw_s) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/isa_win_dpram.sv
module isa_win_dpram #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_rdata <= mem[a_addr];
    end
    if (b_en) begin
      if (b_we) mem[b_addr] <= b_wdata;
      b_rdata <= mem[b_addr];
    end
  end
endmodule

// File: rtl/isa_win_slave.sv
module isa_win_slave
  import isa_win_pkg::*;
#(
  parameter int                BUS_AW    = 20,
  parameter int                BUS_DW    = 16,
  parameter int                BUF_AW    = 10,
  parameter int                WIN_BITS  = 16,
  parameter logic [BUS_AW-1:0] WIN_BASE  = 20'hD0000,
  parameter int                WAIT_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_ale,
  input  logic              bus_aen,
  input  logic              bus_memr_n,
  input  logic              bus_memw_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_d_i,
  output logic [BUS_DW-1:0] bus_d_o,
  output logic              bus_d_oe,
  output logic              bus_rdy,
  input  logic              ub_en,
  input  logic              ub_we,
  input  logic [BUF_AW-1:0] ub_addr,
  input  logic [BUS_DW-1:0] ub_wdata,
  output logic [BUS_DW-1:0] ub_rdata
);
  logic [STROBE_CNT-1:0] strb_raw, strb_s;
  logic ale_s, aen_s, memr_s, memw_s;
  logic hit_q;
  logic [BUF_AW-1:0] idx_q;
  logic a_en, a_we;
  logic [BUF_AW-1:0] a_addr;
  logic [BUS_DW-1:0] a_wdata, a_rdata;

  assign strb_raw = {bus_ale, bus_aen, ~bus_memr_n, ~bus_memw_n};
  assign {ale_s, aen_s, memr_s, memw_s} = strb_s;

  isa_win_sync #(.WIDTH(STROBE_CNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(strb_raw), .sync_o(strb_s)
  );

  isa_win_decode #(
    .BUS_AW(BUS_AW), .BUF_AW(BUF_AW), .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .clk(clk), .rst(rst), .ale_s(ale_s), .aen_s(aen_s),
    .bus_addr(bus_addr), .hit_q(hit_q), .idx_q(idx_q)
  );

  isa_win_ctrl #(
    .BUS_DW(BUS_DW), .BUF_AW(BUF_AW), .WAIT_CLKS(WAIT_CLKS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .memr_s(memr_s), .memw_s(memw_s), .aen_s(aen_s),
    .hit_q(hit_q), .idx_q(idx_q), .bus_d_i(bus_d_i),
    .bus_d_o(bus_d_o), .bus_d_oe(bus_d_oe), .bus_rdy(bus_rdy),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata)
  );

  isa_win_dpram #(.AW(BUF_AW), .DW(BUS_DW)) u_ram (
    .clk(clk),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata),
    .b_en(ub_en), .b_we(ub_we), .b_addr(ub_addr), .b_wdata(ub_wdata),
    .b_rdata(ub_rdata)
  );
endmodule

// File: rtl/isa_win_slave_chk.sv
module isa_win_slave_chk #(
  parameter int WAIT_CLKS = 2
) (
  input logic clk,
  input logic rst,
  input logic bus_rdy,
  input logic bus_d_oe,
  input logic bus_memr_n,
  input logic a_we,
  input logic hit_q,
  input logic aen_s
);
  logic [7:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) low_cnt <= '0;
    else if (bus_rdy) low_cnt <= '0;
    else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 1'b1;
  end

  // R5: ready low never lasts beyond the wait count
  assert_rdy_max_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_rdy |-> (low_cnt < 8'(WAIT_CLKS)));

  // R5: ready low lasts at least two clocks
  assert_rdy_min_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rdy) |=> !bus_rdy);

  // R6: ready only stretched while the slave drives data
  assert_rdy_oe_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_rdy |-> bus_d_oe);

  // R6: output enable released after the read strobe has been high a while
  assert_oe_release_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_memr_n, 1) && $past(bus_memr_n, 2) && $past(bus_memr_n, 3))
      |-> !bus_d_oe);

  // R3 and R4: buffer writes only follow a decoded, non-DMA cycle
  assert_wr_decoded_R3: assert property (@(posedge clk) disable iff (rst)
    a_we |-> $past(hit_q && !aen_s));
endmodule

bind isa_win_slave isa_win_slave_chk #(.WAIT_CLKS(WAIT_CLKS)) u_chk (
  .clk(clk), .rst(rst), .bus_rdy(bus_rdy), .bus_d_oe(bus_d_oe),
  .bus_memr_n(bus_memr_n), .a_we(a_we), .hit_q(hit_q), .aen_s(aen_s)
);

// File: tb/isa_win_slave_tb.sv
module isa_win_slave_tb;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int BW = 10;
  localparam int WAITC = 2;

  logic clk = 1'b0;
  logic rst;
  logic bus_ale, bus_aen, bus_memr_n, bus_memw_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_d_i, bus_d_o, ub_wdata, ub_rdata;
  logic bus_d_oe, bus_rdy, ub_en, ub_we;
  logic [BW-1:0] ub_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  isa_win_slave #(.BUF_AW(BW), .WAIT_CLKS(WAITC)) u_dut (
    .clk(clk), .rst(rst), .bus_ale(bus_ale), .bus_aen(bus_aen),
    .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n), .bus_addr(bus_addr),
    .bus_d_i(bus_d_i), .bus_d_o(bus_d_o), .bus_d_oe(bus_d_oe),
    .bus_rdy(bus_rdy), .ub_en(ub_en), .ub_we(ub_we), .ub_addr(ub_addr),
    .ub_wdata(ub_wdata), .ub_rdata(ub_rdata)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic local_write(input logic [BW-1:0] a, input logic [DW-1:0] d);
    ub_en = 1; ub_we = 1; ub_addr = a; ub_wdata = d;
    tick(1);
    ub_en = 0; ub_we = 0;
  endtask

  task automatic local_read(input logic [BW-1:0] a, output logic [DW-1:0] d);
    ub_en = 1; ub_we = 0; ub_addr = a;
    tick(1);
    ub_en = 0;
    d = ub_rdata;
  endtask

  task automatic addr_phase(input logic [AW-1:0] a, input logic aen);
    bus_aen = aen; bus_addr = a; bus_ale = 1;
    tick(3);
    bus_ale = 0;
    tick(4);
  endtask

  task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic aen);
    addr_phase(a, aen);
    bus_d_i = d; bus_memw_n = 0;
    tick(6);
    bus_memw_n = 1;
    tick(5);
    bus_aen = 0;
  endtask

  task automatic host_read(input logic [AW-1:0] a, input logic aen,
                           output logic [DW-1:0] d, output int lows,
                           output logic saw_oe, input logic move_addr);
    logic seen_low;
    addr_phase(a, aen);
    if (move_addr) bus_addr = a ^ 20'h0000F;
    bus_memr_n = 0;
    lows = 0; seen_low = 0; saw_oe = 0; d = '0;
    for (int i = 0; i < 16; i++) begin
      tick(1);
      if (bus_d_oe) saw_oe = 1;
      if (!bus_rdy) begin lows++; seen_low = 1; end
      else if (seen_low) begin d = bus_d_o; break; end
    end
    bus_memr_n = 1;
    tick(6);
    bus_aen = 0;
  endtask

  task automatic t_reset;
    check("R1 rdy", bus_rdy, 1);
    check("R1 oe", bus_d_oe, 0);
  endtask

  task automatic t_host_write_basic;
    logic [DW-1:0] d;
    host_write(20'hD0005, 16'hA55A, 0);
    local_read(10'h005, d);
    check("R2 write", d, 16'hA55A);
  endtask

  task automatic t_window_edges;
    logic [DW-1:0] d;
    host_write(20'hD0000, 16'h1111, 0);
    local_read(10'h000, d);
    check("R2 low edge", d, 16'h1111);
    host_write(20'hDFFFF, 16'h2222, 0);
    local_read(10'h3FF, d);
    check("R2 high edge", d, 16'h2222);
    host_write(20'hE0000, 16'hBAD1, 0);
    local_read(10'h000, d);
    check("R3 above window", d, 16'h1111);
    host_write(20'hCFFFF, 16'hBAD2, 0);
    local_read(10'h3FF, d);
    check("R3 below window", d, 16'h2222);
  endtask

  task automatic t_read_out_of_window;
    logic [DW-1:0] d; int lows; logic oe;
    host_read(20'hC0005, 0, d, lows, oe, 0);
    check("R3 read rdy", lows, 0);
    check("R3 read oe", oe, 0);
  endtask

  task automatic t_aen;
    logic [DW-1:0] d; int lows; logic oe;
    local_write(10'h020, 16'h7E7E);
    host_write(20'hD0020, 16'h0BAD, 1);
    local_read(10'h020, d);
    check("R4 aen write", d, 16'h7E7E);
    host_read(20'hD0020, 1, d, lows, oe, 0);
    check("R4 aen rdy", lows, 0);
    check("R4 aen oe", oe, 0);
  endtask

  task automatic t_read_wait;
    logic [DW-1:0] d; int lows; logic oe;
    local_write(10'h044, 16'hC0DE);
    host_read(20'hD0044, 0, d, lows, oe, 0);
    check("R5 wait clocks", lows, WAITC);
    check("R7 local to host", d, 16'hC0DE);
    check("R6 oe during read", oe, 1);
    check("R6 oe released", bus_d_oe, 0);
    check("R5 rdy idle", bus_rdy, 1);
  endtask

  task automatic t_addr_latch;
    logic [DW-1:0] d; int lows; logic oe;
    local_write(10'h050, 16'h5050);
    local_write(10'h05F, 16'h5F5F);
    host_read(20'hD0050, 0, d, lows, oe, 1);
    check("R8 latched addr", d, 16'h5050);
  endtask

  task automatic t_single_write;
    logic [DW-1:0] d;
    addr_phase(20'hD0066, 0);
    bus_d_i = 16'h6001; bus_memw_n = 0;
    tick(6);
    bus_d_i = 16'h6002;
    tick(6);
    bus_memw_n = 1;
    tick(5);
    local_read(10'h066, d);
    check("R9 one write", d, 16'h6001);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; bus_ale = 0; bus_aen = 0; bus_memr_n = 1; bus_memw_n = 1;
    bus_addr = '0; bus_d_i = '0; ub_en = 0; ub_we = 0; ub_addr = '0;
    ub_wdata = '0;
    tick(4);
    rst = 0;
    tick(1);
    t_reset;
    t_host_write_basic;
    t_window_edges;
    t_read_out_of_window;
    t_aen;
    t_read_wait;
    t_addr_latch;
    t_single_write;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule